// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a video raster, either interlaced (two fields with their own start lines and active windows) or progressive (the second field start line set outside the frame). A pixel counter runs up to a programmed line length and a line counter runs up to a programmed frame height. Programmable window bounds decide, for each count, whether the sample lies in active video. The field flag toggles at two programmed line numbers.

Two settings choose how the block runs. `cfg_master` chooses between free-running counters and counters that lock to external HSYNC, VSYNC and FIELD inputs. `cfg_discrete` chooses between separate blanking and field outputs and a flag-plus-word stream that marks where the four-word start-of-active and end-of-active timing codes are inserted into the data stream. The current pixel and line counts are always available as outputs.

Top module: `raster_timing_gen`

## Requirements
- R1: Out of reset `pixel_count`, `line_count` and the field state are all 0.
- R2: `pixel_count` advances by one on each clock and returns to 0 on the clock after it equals `cfg_h_total`-1.
- R3: `line_count` advances by one on each clock where `pixel_count` wraps, and returns to 0 after line `cfg_v_total`-1.
- R4: In master mode the field state becomes 1 when the line counter enters `cfg_f1_line`, and 0 when it enters `cfg_f0_line`. Otherwise it holds.
- R5: `h_active` is 1 when `cfg_h_act_start` <= `pixel_count` <= `cfg_h_act_end`. `v_active` is 1 when the line lies in the inclusive window of the current field (field 0: `cfg_f0_act_start`..`cfg_f0_act_end`; field 1: `cfg_f1_act_start`..`cfg_f1_act_end`).
- R6: With `cfg_discrete`=1: `out_hsync` = not `h_active`, `out_vsync` = not `v_active`, and `out_field` = field state. `code_flag` and `code_word` are then 0.
- R7: With `cfg_discrete`=0, `code_flag` is 1 on the four counts `cfg_h_act_start`-4..-1 (start code) and on `cfg_h_act_end`+1..+4 (end code). On those counts `code_word` is 0x3FF, 0x000, 0x000, XY in that order. Elsewhere `code_word` is 0, and the three discrete outputs are 0. The windows must satisfy `cfg_h_act_start` >= 4 and `cfg_h_act_end`+4 < `cfg_h_total`.
- R8: XY has bit 9 = 1, bit 8 = F (field), bit 7 = V (1 outside the vertical active window), and bit 6 = H (1 for the end code, 0 for the start code). Bits 5..2 are V^H, F^H, F^V and F^V^H, and bits 1..0 are 0.
- R9: In slave mode, a rising edge on `in_hsync` makes `pixel_count` 0 on the next clock. The count then advances normally.
- R10: In slave mode, a rising edge on `in_vsync` loads `line_count` with `cfg_f1_line` when `in_field` is 1, or with `cfg_f0_line` when it is 0. The field state follows `in_field` one clock later.
- R11: In master mode, `in_hsync`, `in_vsync` and `in_field` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1 = free-running counters, 0 = lock to sync inputs |
| cfg_discrete | input | 1 | 1 = discrete sync outputs, 0 = timing-code insertion flags |
| cfg_h_total | input | HW | Samples per line |
| cfg_v_total | input | VW | Lines per frame |
| cfg_f0_line | input | VW | First line of field 0 |
| cfg_f1_line | input | VW | First line of field 1 |
| cfg_f0_act_start | input | VW | First active line, field 0 |
| cfg_f0_act_end | input | VW | Last active line, field 0 |
| cfg_f1_act_start | input | VW | First active line, field 1 |
| cfg_f1_act_end | input | VW | Last active line, field 1 |
| cfg_h_act_start | input | HW | First active sample |
| cfg_h_act_end | input | HW | Last active sample |
| in_hsync | input | 1 | External line sync (slave mode) |
| in_vsync | input | 1 | External frame sync (slave mode) |
| in_field | input | 1 | External field indicator (slave mode) |
| out_hsync | output | 1 | Horizontal blanking |
| out_vsync | output | 1 | Vertical blanking |
| out_field | output | 1 | Field indicator |
| h_active | output | 1 | Sample in horizontal active window |
| v_active | output | 1 | Line in vertical active window |
| code_flag | output | 1 | Timing-code word slot |
| code_word | output | 10 | Timing-code word |
| pixel_count | output | HW | Current sample count |
| line_count | output | VW | Current line count |

## Verification
The hardest case to reach is the slave re-lock onto field 1. A VSYNC rising edge arrives while `in_field` is high. The line counter must jump to the field-1 start line, and the field state must follow one clock later. The free-running counters never pass through that jump by themselves. The bench gets there by holding the block in slave mode, letting the counters run to an arbitrary count, and then driving the sync and field inputs at chosen cycles. An HSYNC edge comes first, then VSYNC with each field value. After each edge the counts and field are checked on the very next cycle.

// File: rtl/raster_pkg.sv
package raster_pkg;
    localparam int CODE_W = 10;
    localparam int CODE_LEN = 4;
    localparam logic [CODE_W-1:0] CODE_PRE = 10'h3FF;

    function automatic logic [CODE_W-1:0] xy_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    endfunction
endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_total,
    input  logic [VW-1:0] f0_line,
    input  logic [VW-1:0] f1_line,
    input  logic          in_hsync,
    input  logic          in_vsync,
    input  logic          in_field,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          field
);
    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
        logic          f;
        logic          hs;
        logic          vs;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        logic [VW-1:0] nv;
        st_d    = st_q;
        st_d.hs = in_hsync;
        st_d.vs = in_vsync;
        nv      = st_q.v;
        if (st_q.h >= h_total - HW'(1)) begin
            st_d.h = '0;
            nv = (st_q.v >= v_total - VW'(1)) ? '0 : st_q.v + VW'(1);
            st_d.v = nv;
            if (master) begin
                if (nv == f1_line)      st_d.f = 1'b1;
                else if (nv == f0_line) st_d.f = 1'b0;
            end
        end else begin
            st_d.h = st_q.h + HW'(1);
        end
        if (!master) begin
            if (in_hsync && !st_q.hs) st_d.h = '0;
            if (in_vsync && !st_q.vs) st_d.v = in_field ? f1_line : f0_line;
            st_d.f = in_field;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hcnt  = st_q.h;
    assign vcnt  = st_q.v;
    assign field = st_q.f;
endmodule

// File: rtl/raster_window.sv
module raster_window #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          field,
    input  logic [HW-1:0] h_start,
    input  logic [HW-1:0] h_end,
    input  logic [VW-1:0] f0_start,
    input  logic [VW-1:0] f0_end,
    input  logic [VW-1:0] f1_start,
    input  logic [VW-1:0] f1_end,
    output logic          h_act,
    output logic          v_act
);
    logic [VW-1:0] lo, hi;

    always_comb begin
        lo    = field ? f1_start : f0_start;
        hi    = field ? f1_end   : f0_end;
        h_act = (hcnt >= h_start) && (hcnt <= h_end);
        v_act = (vcnt >= lo) && (vcnt <= hi);
    end
endmodule

// File: rtl/raster_code.sv
module raster_code #(
    parameter int HW = 12
) (
    input  logic [HW-1:0]                  hcnt,
    input  logic [HW-1:0]                  h_start,
    input  logic [HW-1:0]                  h_end,
    input  logic                           field,
    input  logic                           v_blank,
    output logic                           flag,
    output logic [raster_pkg::CODE_W-1:0]  word
);
    import raster_pkg::*;

    logic [HW-1:0] off_s, off_e, off;
    logic          in_s, in_e;

    always_comb begin
        off_s = hcnt - (h_start - HW'(CODE_LEN));
        off_e = hcnt - (h_end + HW'(1));
        in_s  = off_s < HW'(CODE_LEN);
        in_e  = off_e < HW'(CODE_LEN);
        flag  = in_s || in_e;
        off   = in_e ? off_e : off_s;
        word  = '0;
        if (flag) begin
            if (off == HW'(0))                 word = CODE_PRE;
            else if (off == HW'(CODE_LEN - 1)) word = xy_word(field, v_blank, in_e);
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic          cfg_discrete,
    input  logic [HW-1:0] cfg_h_total,
    input  logic [VW-1:0] cfg_v_total,
    input  logic [VW-1:0] cfg_f0_line,
    input  logic [VW-1:0] cfg_f1_line,
    input  logic [VW-1:0] cfg_f0_act_start,
    input  logic [VW-1:0] cfg_f0_act_end,
    input  logic [VW-1:0] cfg_f1_act_start,
    input  logic [VW-1:0] cfg_f1_act_end,
    input  logic [HW-1:0] cfg_h_act_start,
    input  logic [HW-1:0] cfg_h_act_end,
    input  logic          in_hsync,
    input  logic          in_vsync,
    input  logic          in_field,
    output logic          out_hsync,
    output logic          out_vsync,
    output logic          out_field,
    output logic          h_active,
    output logic          v_active,
    output logic          code_flag,
    output logic [9:0]    code_word,
    output logic [HW-1:0] pixel_count,
    output logic [VW-1:0] line_count
);
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          field, h_act, v_act, cflag;
    logic [9:0]    cword;

    raster_counters #(.HW(HW), .VW(VW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .master(cfg_master),
        .h_total(cfg_h_total), .v_total(cfg_v_total),
        .f0_line(cfg_f0_line), .f1_line(cfg_f1_line),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
        .hcnt(hcnt), .vcnt(vcnt), .field(field)
    );

    raster_window #(.HW(HW), .VW(VW)) u_win (
        .hcnt(hcnt), .vcnt(vcnt), .field(field),
        .h_start(cfg_h_act_start), .h_end(cfg_h_act_end),
        .f0_start(cfg_f0_act_start), .f0_end(cfg_f0_act_end),
        .f1_start(cfg_f1_act_start), .f1_end(cfg_f1_act_end),
        .h_act(h_act), .v_act(v_act)
    );

    raster_code #(.HW(HW)) u_code (
        .hcnt(hcnt), .h_start(cfg_h_act_start), .h_end(cfg_h_act_end),
        .field(field), .v_blank(!v_act),
        .flag(cflag), .word(cword)
    );

    always_comb begin
        out_hsync = cfg_discrete & ~h_act;
        out_vsync = cfg_discrete & ~v_act;
        out_field = cfg_discrete & field;
        code_flag = ~cfg_discrete & cflag;
        code_word = cfg_discrete ? '0 : cword;
    end

    assign h_active    = h_act;
    assign v_active    = v_act;
    assign pixel_count = hcnt;
    assign line_count  = vcnt;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_master,
    input logic          cfg_discrete,
    input logic [HW-1:0] cfg_h_total,
    input logic [VW-1:0] cfg_v_total,
    input logic          in_hsync,
    input logic          in_field,
    input logic          out_field,
    input logic          h_active,
    input logic          code_flag,
    input logic [HW-1:0] pixel_count,
    input logic [VW-1:0] line_count
);
    p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && (pixel_count < cfg_h_total - HW'(1)) |=> pixel_count == $past(pixel_count) + HW'(1));

    p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && (pixel_count == cfg_h_total - HW'(1)) |=> pixel_count == '0);

    p_v_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master && (pixel_count == cfg_h_total - HW'(1)) && (line_count == cfg_v_total - VW'(1))
        |=> line_count == '0);

    p_code_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_flag |-> !h_active);

    p_slave_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master && $rose(in_hsync) |=> pixel_count == '0);

    p_slave_field_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master && cfg_discrete |=> out_field == $past(in_field));
endmodule

bind raster_timing_gen raster_timing_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_discrete(cfg_discrete),
    .cfg_h_total(cfg_h_total), .cfg_v_total(cfg_v_total),
    .in_hsync(in_hsync), .in_field(in_field), .out_field(out_field),
    .h_active(h_active), .code_flag(code_flag),
    .pixel_count(pixel_count), .line_count(line_count)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int HT = 20, VT = 10, F0 = 0, F1 = 5;
    localparam int HS = 6, HE = 15, A0S = 1, A0E = 3, A1S = 6, A1E = 8;

    logic clk = 0, rst_n = 0;
    logic cfg_master = 1, cfg_discrete = 1;
    logic in_hsync = 0, in_vsync = 0, in_field = 0;
    logic out_hsync, out_vsync, out_field, h_active, v_active, code_flag;
    logic [9:0] code_word;
    logic [HW-1:0] pixel_count;
    logic [VW-1:0] line_count;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    raster_timing_gen #(.HW(HW), .VW(VW)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_discrete(cfg_discrete),
        .cfg_h_total(HW'(HT)), .cfg_v_total(VW'(VT)),
        .cfg_f0_line(VW'(F0)), .cfg_f1_line(VW'(F1)),
        .cfg_f0_act_start(VW'(A0S)), .cfg_f0_act_end(VW'(A0E)),
        .cfg_f1_act_start(VW'(A1S)), .cfg_f1_act_end(VW'(A1E)),
        .cfg_h_act_start(HW'(HS)), .cfg_h_act_end(HW'(HE)),
        .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
        .out_hsync(out_hsync), .out_vsync(out_vsync), .out_field(out_field),
        .h_active(h_active), .v_active(v_active), .code_flag(code_flag),
        .code_word(code_word), .pixel_count(pixel_count), .line_count(line_count)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic master, input logic discrete);
        @(negedge clk);
        rst_n = 0; cfg_master = master; cfg_discrete = discrete;
        in_hsync = 0; in_vsync = 0; in_field = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    // Free-running frame compared against a model built from R2..R8; optional sync wiggle (R11).
    task automatic run_frames(input logic discrete, input logic wiggle, input int ncyc);
        int mh = 0, mv = 0, mf = 0;
        do_reset(1'b1, discrete);
        chk("R1", "pixel_count after reset", pixel_count, 0);
        chk("R1", "line_count after reset", line_count, 0);
        for (int n = 0; n < ncyc; n++) begin
            int ha, va, cf, cw, so, eo, f, v;
            ha = (mh >= HS && mh <= HE);
            va = mf ? (mv >= A1S && mv <= A1E) : (mv >= A0S && mv <= A0E);
            chk(wiggle ? "R11" : "R2", "pixel_count", pixel_count, mh);
            chk(wiggle ? "R11" : "R3", "line_count", line_count, mv);
            chk("R5", "h_active", h_active, ha);
            chk("R5", "v_active", v_active, va);
            if (discrete) begin
                chk("R6", "out_hsync", out_hsync, !ha);
                chk("R6", "out_vsync", out_vsync, !va);
                chk("R4", "out_field", out_field, mf);
                chk("R6", "code_flag", code_flag, 0);
            end else begin
                so = mh - (HS - 4); eo = mh - (HE + 1);
                cf = (so >= 0 && so < 4) || (eo >= 0 && eo < 4);
                f = mf; v = !va;
                cw = 0;
                if (cf) begin
                    int o;
                    int h;
                    h = (eo >= 0 && eo < 4);
                    o = h ? eo : so;
                    if (o == 0) cw = 'h3FF;
                    else if (o == 3)
                        cw = 512 + f*256 + v*128 + h*64 + (v^h)*32 + (f^h)*16 + (f^v)*8 + (f^v^h)*4;
                end
                chk("R7", "code_flag", code_flag, cf);
                chk(cf ? "R8" : "R7", "code_word", code_word, cw);
                chk("R7", "discrete outs", {out_hsync, out_vsync, out_field}, 0);
            end
            if (wiggle) begin
                in_hsync = n[2]; in_vsync = n[3]; in_field = n[1];
            end
            if (mh == HT - 1) begin
                mh = 0;
                mv = (mv == VT - 1) ? 0 : mv + 1;
                if (mv == F1) mf = 1;
                else if (mv == F0) mf = 0;
            end else mh++;
            @(negedge clk);
        end
        in_hsync = 0; in_vsync = 0; in_field = 0;
    endtask

    task automatic test_master_discrete();
        run_frames(1'b1, 1'b0, 2 * HT * VT + 7);
    endtask

    task automatic test_master_embedded();
        run_frames(1'b0, 1'b0, HT * VT + 3);
    endtask

    task automatic test_master_ignores_sync();
        run_frames(1'b1, 1'b1, HT * VT);
    endtask

    task automatic test_slave_lock();
        do_reset(1'b0, 1'b1);
        repeat (7) @(negedge clk);
        chk("R9", "free run before edge", pixel_count, 7);
        in_hsync = 1;
        @(negedge clk);
        chk("R9", "pixel_count after hsync edge", pixel_count, 0);
        @(negedge clk);
        chk("R9", "pixel_count one later", pixel_count, 1);
        in_hsync = 0;
        repeat (4) @(negedge clk);
        in_field = 1; in_vsync = 1;
        @(negedge clk);
        chk("R10", "line_count after vsync field1", line_count, F1);
        chk("R10", "out_field after vsync field1", out_field, 1);
        chk("R5", "v_active on field1 start line", v_active, 0);
        in_vsync = 0; in_field = 0;
        @(negedge clk);
        chk("R10", "out_field follows in_field", out_field, 0);
        chk("R10", "line held without edge", line_count, F1);
        in_hsync = 1; in_vsync = 1; in_field = 0;
        @(negedge clk);
        chk("R10", "line_count after vsync field0", line_count, F0);
        chk("R9", "pixel_count after second hsync", pixel_count, 0);
        @(negedge clk);
        chk("R10", "held level is no edge", line_count, F0);
        in_hsync = 0; in_vsync = 0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_master_discrete();
        test_master_embedded();
        test_master_ignores_sync();
        test_slave_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule